// File: doc/BRIEF.md
# Register-Mapped Debug Serial Port

A small serial port for console and bring-up traffic, reached through a synchronous 32-bit register port. Software sets a baud divisor, picks a parity option and a line routing mode, enables the transmitter and receiver with pulse bits in a write-only command register, and then moves single characters through a transmit holding register and a receive holding register. Frames are fixed at one start bit, eight data bits sent least significant bit first, an optional parity bit and one stop bit. Both directions run from a shared tick at sixteen times the bit rate.

Status flags report receive-ready, transmit-ready, transmitter-empty and three sticky receive errors: overrun, framing and parity. A mask register is built up through separate set and clear registers, and a single level interrupt is raised whenever a masked-in status flag is high. Four routing modes let the port run normally, echo the incoming line back out, loop its own transmitter into its receiver, or hand the line straight back to the far end.

Register offsets: 0x00 command (write), 0x04 mode, 0x08 mask set (write), 0x0C mask clear (write), 0x10 mask (read), 0x14 status (read), 0x18 receive holding (read), 0x1C transmit holding (write), 0x20 baud divisor. Unlisted reads return 0.

Top module: `sercon_uart`

## Requirements
- R1: After reset the status, mask, receive holding and divisor registers read 0, the interrupt output is low and the serial output is high; both directions start disabled.
- R2: Command bits are write-one pulses: bit 6 enables and bit 7 disables the transmitter (disable wins), bit 4 enables and bit 5 disables the receiver. Status bit 1 (transmit-ready) and bit 9 (transmitter-empty) read 0 while the transmitter is disabled; an enabled idle transmitter reads status 0x202.
- R3: A byte written to offset 0x1C while transmit-ready is set is sent as a low start bit, eight data bits LSB first and a high stop bit, each bit lasting 16 x divisor clocks; transmitter-empty returns once the stop bit has finished.
- R4: Mode bits [11:9] select parity: 000 even (bit makes the count of ones even), 001 odd, 010 always 0, 011 always 1, 1xx no parity bit; the parity bit sits between data bit 7 and the stop bit.
- R5: A received frame is loaded into offset 0x18 and sets status bit 0 (receive-ready); reading offset 0x18 clears bit 0.
- R6: A frame completing while bit 0 is still set sets sticky status bit 5 (overrun) and replaces the held byte; command bit 8 clears bits 5, 6 and 7.
- R7: A low stop bit sets sticky status bit 6 (framing error) and the byte is still loaded; no new start bit is accepted until the line has been seen high again.
- R8: With parity enabled, a received parity bit that differs from the one the selected option calls for sets sticky status bit 7.
- R9: The receiver rechecks the start bit at its middle (8 ticks after the falling edge is seen) and discards a low pulse that has already ended.
- R10: Writing ones to 0x08 sets mask bits, writing ones to 0x0C clears them, 0x10 reads the mask, and the interrupt output is high exactly when some status bit and its mask bit are both set.
- R11: Mode bits [15:14]: 00 normal; 01 echo (serial input copied to serial output, receiver still works); 10 local loop (transmitter feeds receiver, serial output held high); 11 remote loop (serial input copied to serial output, receiver sees an idle line).
- R12: A divisor of 0 stops the baud tick: a written byte stays in the holding register, the serial output stays high and transmit-ready stays 0 until a nonzero divisor is written.
- R13: Command bit 3 abandons the frame in flight and empties the transmit holding register (output high, status 0x202 with the transmitter enabled); command bit 2 returns the receiver to idle and clears receive-ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after a read access |
| ser_rxd | input | 1 | Serial input line |
| ser_txd | output | 1 | Serial output line |
| irq | output | 1 | Level interrupt, OR of status AND mask |

## Verification
A wrong receive state shows at the ports within one frame: a misplaced sample point or a bad parity compare changes the byte read at 0x18 or raises an error bit in the status read right after the stop bit. A stuck holding-register flag shows in the very next status read as a wrong transmit-ready or transmitter-empty bit, and a routing mistake shows on the serial output within one clock of a change on the serial input. A baud tick that runs when it should not shows as a falling edge on the serial output during a window in which the line must stay high, and an interrupt mask fault shows on the interrupt pin one clock after the mask write.

// File: rtl/sercon_pkg.sv
// Shared constants, types and the parity function of the debug serial port.
// Assumes a 32-bit register port and fixed 8-bit characters.
package sercon_pkg;

    localparam int STAT_W = 10;

    // register offsets
    localparam int OFF_CMD  = 'h00;
    localparam int OFF_MODE = 'h04;
    localparam int OFF_MSET = 'h08;
    localparam int OFF_MCLR = 'h0C;
    localparam int OFF_MASK = 'h10;
    localparam int OFF_STAT = 'h14;
    localparam int OFF_RBUF = 'h18;
    localparam int OFF_TBUF = 'h1C;
    localparam int OFF_DIV  = 'h20;

    // status bit positions (mask registers use the same layout)
    localparam int ST_RXRDY  = 0;
    localparam int ST_TXRDY  = 1;
    localparam int ST_OVER   = 5;
    localparam int ST_FRAME  = 6;
    localparam int ST_PARITY = 7;
    localparam int ST_TXIDLE = 9;

    localparam logic [STAT_W-1:0] STAT_VALID =
        STAT_W'((1 << ST_RXRDY) | (1 << ST_TXRDY) | (1 << ST_OVER) |
                (1 << ST_FRAME) | (1 << ST_PARITY) | (1 << ST_TXIDLE));

    // command pulse bit positions
    localparam int CM_RX_RST = 2;
    localparam int CM_TX_RST = 3;
    localparam int CM_RX_ON  = 4;
    localparam int CM_RX_OFF = 5;
    localparam int CM_TX_ON  = 6;
    localparam int CM_TX_OFF = 7;
    localparam int CM_ST_CLR = 8;

    typedef enum logic [1:0] {
        CH_NORMAL = 2'b00,
        CH_ECHO   = 2'b01,
        CH_LOCAL  = 2'b10,
        CH_REMOTE = 2'b11
    } chan_mode_t;

    typedef enum logic [2:0] {
        LN_IDLE,
        LN_START,
        LN_DATA,
        LN_PAR,
        LN_STOP
    } line_st_t;

    // Parity bit that goes with a byte for the given parity option.
    function automatic logic par_bit(input logic [7:0] d, input logic [2:0] m);
        case (m)
            3'b000:  par_bit = ^d;
            3'b001:  par_bit = ~^d;
            3'b010:  par_bit = 1'b0;
            3'b011:  par_bit = 1'b1;
            default: par_bit = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/sercon_baud.sv
// Baud tick generator: one-cycle pulse every DIV clocks (16 per bit).
// Assumes the divisor may change at any time; a divisor of 0 stops ticks.
module sercon_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    // Count clocks up to divisor-1 and pulse the tick on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (div == '0) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= div - 1'b1) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/sercon_tx.sv
// Transmit serializer: takes a byte from the holding register on a tick
// while idle and enabled, then shifts start, data, parity and stop bits.
// Assumes the holding register lives in the register bank.
module sercon_tx
    import sercon_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       clear,
    input  logic       enable,
    input  logic [2:0] par_mode,
    input  logic       hold_full,
    input  logic [7:0] hold_data,
    output logic       take,
    output logic       line,
    output logic       idle
);
    line_st_t   st;
    logic [3:0] sub;
    logic [2:0] bitn;
    logic [7:0] shreg;
    logic       pbit;

    // Accept a new byte only on a tick from idle.
    assign take = (st == LN_IDLE) && tick && enable && hold_full && !clear;
    assign idle = (st == LN_IDLE);

    // Frame sequencer: each bit lasts 16 ticks.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            st    <= LN_IDLE;
            sub   <= '0;
            bitn  <= '0;
            shreg <= '0;
            pbit  <= 1'b0;
            line  <= 1'b1;
        end else if (tick) begin
            case (st)
                LN_IDLE: begin
                    sub  <= '0;
                    line <= 1'b1;
                    if (take) begin
                        shreg <= hold_data;
                        pbit  <= par_bit(hold_data, par_mode);
                        st    <= LN_START;
                        line  <= 1'b0;
                    end
                end
                LN_START: begin
                    sub <= sub + 1'b1;
                    if (sub == 4'd15) begin
                        st   <= LN_DATA;
                        bitn <= '0;
                        line <= shreg[0];
                    end
                end
                LN_DATA: begin
                    sub <= sub + 1'b1;
                    if (sub == 4'd15) begin
                        if (bitn == 3'd7) begin
                            if (par_mode[2]) begin
                                st   <= LN_STOP;
                                line <= 1'b1;
                            end else begin
                                st   <= LN_PAR;
                                line <= pbit;
                            end
                        end else begin
                            bitn  <= bitn + 1'b1;
                            shreg <= shreg >> 1;
                            line  <= shreg[1];
                        end
                    end
                end
                LN_PAR: begin
                    sub <= sub + 1'b1;
                    if (sub == 4'd15) begin
                        st   <= LN_STOP;
                        line <= 1'b1;
                    end
                end
                LN_STOP: begin
                    sub <= sub + 1'b1;
                    if (sub == 4'd15) st <= LN_IDLE;
                end
                default: st <= LN_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sercon_rx.sv
// Receive deserializer: synchronizes the line, validates the start bit at
// its middle, samples each later bit at its middle and reports a byte with
// its error flags through a one-cycle load pulse.
// Assumes the line may be asynchronous to clk.
module sercon_rx
    import sercon_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       clear,
    input  logic       enable,
    input  logic [2:0] par_mode,
    input  logic       line_in,
    output logic       load,
    output logic [7:0] data,
    output logic       perr,
    output logic       ferr
);
    logic       rx_m, rx_s;
    logic       armed;
    line_st_t   st;
    logic [3:0] sub;
    logic [2:0] bitn;
    logic [7:0] shreg;
    logic       pbit;

    // Two-flop synchronizer on the incoming line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_m <= 1'b1;
            rx_s <= 1'b1;
        end else begin
            rx_m <= line_in;
            rx_s <= rx_m;
        end
    end

    // Frame sampler and result register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= LN_IDLE;
            sub   <= '0;
            bitn  <= '0;
            shreg <= '0;
            pbit  <= 1'b0;
            armed <= 1'b0;
            load  <= 1'b0;
            data  <= '0;
            perr  <= 1'b0;
            ferr  <= 1'b0;
        end else begin
            load <= 1'b0;
            if (clear) begin
                st    <= LN_IDLE;
                sub   <= '0;
                bitn  <= '0;
                armed <= 1'b0;
            end else if (tick) begin
                case (st)
                    LN_IDLE: begin
                        sub <= '0;
                        if (rx_s) armed <= 1'b1;
                        else if (armed && enable) st <= LN_START;
                    end
                    LN_START: begin
                        sub <= sub + 1'b1;
                        if (sub == 4'd7) begin
                            sub <= '0;
                            if (!rx_s) begin
                                st   <= LN_DATA;
                                bitn <= '0;
                            end else begin
                                st <= LN_IDLE;
                            end
                        end
                    end
                    LN_DATA: begin
                        sub <= sub + 1'b1;
                        if (sub == 4'd15) begin
                            shreg <= {rx_s, shreg[7:1]};
                            if (bitn == 3'd7) st <= par_mode[2] ? LN_STOP : LN_PAR;
                            else bitn <= bitn + 1'b1;
                        end
                    end
                    LN_PAR: begin
                        sub <= sub + 1'b1;
                        if (sub == 4'd15) begin
                            pbit <= rx_s;
                            st   <= LN_STOP;
                        end
                    end
                    LN_STOP: begin
                        sub <= sub + 1'b1;
                        if (sub == 4'd15) begin
                            st    <= LN_IDLE;
                            armed <= 1'b0;
                            load  <= 1'b1;
                            data  <= shreg;
                            ferr  <= !rx_s;
                            perr  <= !par_mode[2] && (pbit != par_bit(shreg, par_mode));
                        end
                    end
                    default: st <= LN_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/sercon_uart.sv
// Debug serial port top: register bank, status and interrupt logic, line
// routing for the four channel modes, and the baud, transmit and receive
// engines. Assumes DATA_W >= 16 and DIV_W <= DATA_W; reads return data
// one cycle after the access.
module sercon_uart
    import sercon_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int DIV_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ser_rxd,
    output logic              ser_txd,
    output logic              irq
);
    // register state
    logic              tx_en, rx_en;
    chan_mode_t        chmode_q;
    logic [2:0]        par_q;
    logic [STAT_W-1:0] mask_q;
    logic [DIV_W-1:0]  div_q;
    logic [7:0]        thr_q;
    logic              thr_full;
    logic [7:0]        rhr_q;
    logic              rxrdy, ovre, ferr_q, perr_q;

    // engine interconnect
    logic       tick, tx_take, tx_line, tx_idle;
    logic       rx_load, rx_perr, rx_ferr;
    logic [7:0] rx_data;
    logic       rx_route;

    // access decode
    logic wr_acc, rd_acc;
    logic wr_cmd, wr_mode, wr_mset, wr_mclr, wr_tbuf, wr_div;
    logic rhr_rd;
    logic tx_rst, rx_rst, sta_clr;
    logic [STAT_W-1:0] stat;
    logic txrdy, txempty;

    assign wr_acc  = bus_sel && bus_wr;
    assign rd_acc  = bus_sel && !bus_wr;
    assign wr_cmd  = wr_acc && (bus_addr == ADDR_W'(OFF_CMD));
    assign wr_mode = wr_acc && (bus_addr == ADDR_W'(OFF_MODE));
    assign wr_mset = wr_acc && (bus_addr == ADDR_W'(OFF_MSET));
    assign wr_mclr = wr_acc && (bus_addr == ADDR_W'(OFF_MCLR));
    assign wr_tbuf = wr_acc && (bus_addr == ADDR_W'(OFF_TBUF));
    assign wr_div  = wr_acc && (bus_addr == ADDR_W'(OFF_DIV));
    assign rhr_rd  = rd_acc && (bus_addr == ADDR_W'(OFF_RBUF));
    assign tx_rst  = wr_cmd && bus_wdata[CM_TX_RST];
    assign rx_rst  = wr_cmd && bus_wdata[CM_RX_RST];
    assign sta_clr = wr_cmd && bus_wdata[CM_ST_CLR];

    // Status vector assembly.
    assign txrdy   = tx_en && !thr_full;
    assign txempty = txrdy && tx_idle;
    always_comb begin
        stat            = '0;
        stat[ST_RXRDY]  = rxrdy;
        stat[ST_TXRDY]  = txrdy;
        stat[ST_OVER]   = ovre;
        stat[ST_FRAME]  = ferr_q;
        stat[ST_PARITY] = perr_q;
        stat[ST_TXIDLE] = txempty;
    end

    // Level interrupt from masked status.
    assign irq = |(stat & mask_q);

    // Enable flags, mode and divisor registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_en    <= 1'b0;
            rx_en    <= 1'b0;
            chmode_q <= CH_NORMAL;
            par_q    <= 3'b000;
            div_q    <= '0;
        end else begin
            if (wr_cmd) begin
                if (bus_wdata[CM_TX_OFF])     tx_en <= 1'b0;
                else if (bus_wdata[CM_TX_ON]) tx_en <= 1'b1;
                if (bus_wdata[CM_RX_OFF])     rx_en <= 1'b0;
                else if (bus_wdata[CM_RX_ON]) rx_en <= 1'b1;
            end
            if (wr_mode) begin
                chmode_q <= chan_mode_t'(bus_wdata[15:14]);
                par_q    <= bus_wdata[11:9];
            end
            if (wr_div) div_q <= bus_wdata[DIV_W-1:0];
        end
    end

    // Interrupt mask set/clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (wr_mset) begin
            mask_q <= mask_q | (bus_wdata[STAT_W-1:0] & STAT_VALID);
        end else if (wr_mclr) begin
            mask_q <= mask_q & ~bus_wdata[STAT_W-1:0];
        end
    end

    // Transmit holding register: filled by software, emptied by the engine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_q    <= '0;
            thr_full <= 1'b0;
        end else if (tx_rst) begin
            thr_full <= 1'b0;
        end else if (tx_take) begin
            thr_full <= 1'b0;
        end else if (wr_tbuf && txrdy) begin
            thr_q    <= bus_wdata[7:0];
            thr_full <= 1'b1;
        end
    end

    // Receive holding register and the receive flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rhr_q  <= '0;
            rxrdy  <= 1'b0;
            ovre   <= 1'b0;
            ferr_q <= 1'b0;
            perr_q <= 1'b0;
        end else begin
            if (rx_load) rhr_q <= rx_data;
            if (rx_rst)       rxrdy <= 1'b0;
            else if (rx_load) rxrdy <= 1'b1;
            else if (rhr_rd)  rxrdy <= 1'b0;
            if (sta_clr) begin
                ovre   <= 1'b0;
                ferr_q <= 1'b0;
                perr_q <= 1'b0;
            end else if (rx_load) begin
                if (rxrdy && !rhr_rd) ovre <= 1'b1;
                if (rx_ferr) ferr_q <= 1'b1;
                if (rx_perr) perr_q <= 1'b1;
            end
        end
    end

    // Registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (rd_acc) begin
            bus_rdata <= '0;
            case (bus_addr)
                ADDR_W'(OFF_MODE): begin
                    bus_rdata[15:14] <= chmode_q;
                    bus_rdata[11:9]  <= par_q;
                end
                ADDR_W'(OFF_MASK): bus_rdata[STAT_W-1:0] <= mask_q;
                ADDR_W'(OFF_STAT): bus_rdata[STAT_W-1:0] <= stat;
                ADDR_W'(OFF_RBUF): bus_rdata[7:0]        <= rhr_q;
                ADDR_W'(OFF_DIV):  bus_rdata[DIV_W-1:0]  <= div_q;
                default: ;
            endcase
        end
    end

    // Line routing for the channel modes.
    always_comb begin
        case (chmode_q)
            CH_ECHO:   begin rx_route = ser_rxd; ser_txd = ser_rxd; end
            CH_LOCAL:  begin rx_route = tx_line; ser_txd = 1'b1;    end
            CH_REMOTE: begin rx_route = 1'b1;    ser_txd = ser_rxd; end
            default:   begin rx_route = ser_rxd; ser_txd = tx_line; end
        endcase
    end

    sercon_baud #(.DIV_W(DIV_W)) u_baud (
        .clk  (clk),
        .rst_n(rst_n),
        .div  (div_q),
        .tick (tick)
    );

    sercon_tx u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .clear    (tx_rst),
        .enable   (tx_en),
        .par_mode (par_q),
        .hold_full(thr_full),
        .hold_data(thr_q),
        .take     (tx_take),
        .line     (tx_line),
        .idle     (tx_idle)
    );

    sercon_rx u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .clear   (rx_rst),
        .enable  (rx_en),
        .par_mode(par_q),
        .line_in (rx_route),
        .load    (rx_load),
        .data    (rx_data),
        .perr    (rx_perr),
        .ferr    (rx_ferr)
    );
endmodule

// File: rtl/sercon_uart_chk.sv
// Property checker for the debug serial port, bound into every instance.
module sercon_uart_chk #(
    parameter int DIV_W  = 16,
    parameter int STAT_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rhr_rd,
    input logic              rx_load,
    input logic              rxrdy,
    input logic              ovre,
    input logic              sta_clr,
    input logic [DIV_W-1:0]  div_q,
    input logic              tick,
    input logic              irq,
    input logic [STAT_W-1:0] mask_q,
    input logic              tx_take,
    input logic              thr_full
);
    // R5
    rhr_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rhr_rd && !rx_load) |=> !rxrdy);

    // R6
    ovre_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovre && !sta_clr) |=> ovre);

    // R6
    ovre_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_load && rxrdy && !rhr_rd && !sta_clr) |=> ovre);

    // R12
    zero_div_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_q == '0) |=> !tick);

    // R10
    irq_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (mask_q != '0));

    // R3
    take_only_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_take |-> thr_full);
endmodule

bind sercon_uart sercon_uart_chk #(.DIV_W(DIV_W), .STAT_W(sercon_pkg::STAT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rhr_rd  (rhr_rd),
    .rx_load (rx_load),
    .rxrdy   (rxrdy),
    .ovre    (ovre),
    .sta_clr (sta_clr),
    .div_q   (div_q),
    .tick    (tick),
    .irq     (irq),
    .mask_q  (mask_q),
    .tx_take (tx_take),
    .thr_full(thr_full)
);

// File: tb/tb_sercon_uart.sv
// Directed bench for the debug serial port: one task per scenario.
module tb_sercon_uart;
    localparam int DIVV = 2;
    localparam int BITC = 16 * DIVV;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ser_rxd = 1'b1;
    logic        ser_txd;
    logic        irq;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    sercon_uart dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ser_rxd(ser_rxd), .ser_txd(ser_txd), .irq(irq)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    function automatic logic exp_par(input logic [7:0] d, input int m);
        case (m)
            0: return ^d;
            1: return ~^d;
            2: return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

    task automatic drive_rx(input logic [7:0] d, input bit use_par, input bit pb, input bit stop_lvl);
        @(negedge clk);
        ser_rxd = 1'b0;
        repeat (BITC) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            ser_rxd = d[i];
            repeat (BITC) @(negedge clk);
        end
        if (use_par) begin
            ser_rxd = pb;
            repeat (BITC) @(negedge clk);
        end
        ser_rxd = stop_lvl;
        repeat (BITC) @(negedge clk);
        ser_rxd = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic capture_tx(input bit has_par, output logic [7:0] d, output logic p,
                              output logic stop, output int low_len);
        int guard = 0;
        d = '0; p = 1'b0; stop = 1'b0; low_len = 0;
        while (ser_txd !== 1'b0 && guard < 4000) begin
            @(negedge clk);
            guard++;
        end
        while (ser_txd === 1'b0 && low_len < 4000) begin
            @(negedge clk);
            low_len++;
        end
        repeat (BITC / 2 - 1) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            d[i] = ser_txd;
            if (i < 7) repeat (BITC) @(negedge clk);
        end
        if (has_par) begin
            repeat (BITC) @(negedge clk);
            p = ser_txd;
        end
        repeat (BITC) @(negedge clk);
        stop = ser_txd;
    endtask

    task automatic count_low(input int n, output int lows);
        lows = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (ser_txd !== 1'b1) lows++;
        end
    endtask

    // R1: reset state
    task automatic t_reset();
        logic [31:0] v;
        bus_read(8'h14, v); check("R1 status", v, 32'h0);
        bus_read(8'h10, v); check("R1 mask", v, 32'h0);
        bus_read(8'h18, v); check("R1 rbuf", v, 32'h0);
        bus_read(8'h20, v); check("R1 div", v, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);
        check("R1 txd", {31'b0, ser_txd}, 32'h1);
    endtask

    // R2: enable and disable pulses
    task automatic t_enable();
        logic [31:0] v;
        bus_write(8'h20, DIVV);
        bus_write(8'h04, 32'h800);
        bus_write(8'h00, 32'h50);
        bus_read(8'h14, v); check("R2 enabled status", v, 32'h202);
        bus_write(8'h00, 32'hC0);
        bus_read(8'h14, v); check("R2 disable wins", v, 32'h0);
        bus_write(8'h00, 32'h40);
        bus_read(8'h14, v); check("R2 re-enabled", v, 32'h202);
    endtask

    // R3: basic frame and bit period
    task automatic t_tx_basic();
        logic [31:0] v; logic [7:0] d; logic p, s; int ll;
        bus_write(8'h1C, 32'hA5);
        capture_tx(1'b0, d, p, s, ll);
        check("R3 start length", ll, BITC);
        check("R3 data", {24'b0, d}, 32'hA5);
        check("R3 stop", {31'b0, s}, 32'h1);
        repeat (BITC) @(negedge clk);
        bus_read(8'h14, v); check("R3 empty after frame", v, 32'h202);
    endtask

    // R4: transmit parity options
    task automatic t_tx_parity();
        logic [7:0] d; logic p, s; int ll;
        for (int m = 0; m < 5; m++) begin
            bus_write(8'h04, (m == 4) ? 32'h800 : (m << 9));
            bus_write(8'h1C, 32'h5B);
            capture_tx(m != 4, d, p, s, ll);
            check($sformatf("R4 data mode %0d", m), {24'b0, d}, 32'h5B);
            if (m != 4) check($sformatf("R4 parity mode %0d", m), {31'b0, p}, {31'b0, exp_par(8'h5B, m)});
            check($sformatf("R4 stop mode %0d", m), {31'b0, s}, 32'h1);
            repeat (BITC) @(negedge clk);
        end
        bus_write(8'h04, 32'h800);
    endtask

    // R5: receive and read-clear
    task automatic t_rx_basic();
        logic [31:0] v;
        drive_rx(8'h3C, 1'b0, 1'b0, 1'b1);
        bus_read(8'h14, v); check("R5 rx ready", v, 32'h203);
        bus_read(8'h18, v); check("R5 rbuf", v, 32'h3C);
        bus_read(8'h14, v); check("R5 ready cleared", v, 32'h202);
    endtask

    // R6: overrun
    task automatic t_overrun();
        logic [31:0] v;
        drive_rx(8'h11, 1'b0, 1'b0, 1'b1);
        drive_rx(8'h22, 1'b0, 1'b0, 1'b1);
        bus_read(8'h14, v); check("R6 overrun set", v, 32'h223);
        bus_read(8'h18, v); check("R6 newest byte", v, 32'h22);
        bus_read(8'h14, v); check("R6 overrun sticky", v, 32'h222);
        bus_write(8'h00, 32'h100);
        bus_read(8'h14, v); check("R6 cleared", v, 32'h202);
    endtask

    // R7: framing error
    task automatic t_framing();
        logic [31:0] v;
        drive_rx(8'h77, 1'b0, 1'b0, 1'b0);
        bus_read(8'h14, v); check("R7 framing flag", v, 32'h243);
        bus_read(8'h18, v); check("R7 byte loaded", v, 32'h77);
        repeat (12 * BITC) @(negedge clk);
        bus_read(8'h14, v); check("R7 no false start", v, 32'h242);
        bus_write(8'h00, 32'h100);
    endtask

    // R8: parity error
    task automatic t_rx_parity();
        logic [31:0] v;
        bus_write(8'h04, 32'h000);
        drive_rx(8'h5B, 1'b1, 1'b0, 1'b1);
        bus_read(8'h14, v); check("R8 parity error", v, 32'h283);
        bus_read(8'h18, v); check("R8 byte", v, 32'h5B);
        bus_write(8'h00, 32'h100);
        drive_rx(8'h5B, 1'b1, 1'b1, 1'b1);
        bus_read(8'h14, v); check("R8 good parity", v, 32'h203);
        bus_read(8'h18, v);
        bus_write(8'h04, 32'h800);
    endtask

    // R9: glitch rejection
    task automatic t_glitch();
        logic [31:0] v;
        @(negedge clk); ser_rxd = 1'b0;
        repeat (4) @(negedge clk); ser_rxd = 1'b1;
        repeat (12 * BITC) @(negedge clk);
        bus_read(8'h14, v); check("R9 glitch ignored", v, 32'h202);
    endtask

    // R10: interrupt mask
    task automatic t_irq();
        logic [31:0] v;
        bus_write(8'h08, 32'h1);
        bus_read(8'h10, v); check("R10 mask read", v, 32'h1);
        check("R10 irq idle", {31'b0, irq}, 32'h0);
        drive_rx(8'h0F, 1'b0, 1'b0, 1'b1);
        check("R10 irq on rx", {31'b0, irq}, 32'h1);
        bus_read(8'h18, v);
        check("R10 irq after read", {31'b0, irq}, 32'h0);
        bus_write(8'h08, 32'h2);
        check("R10 irq on txrdy", {31'b0, irq}, 32'h1);
        bus_write(8'h0C, 32'h3);
        bus_read(8'h10, v); check("R10 mask cleared", v, 32'h0);
        check("R10 irq off", {31'b0, irq}, 32'h0);
    endtask

    // R11: channel modes
    task automatic t_modes();
        logic [31:0] v; int lows;
        bus_write(8'h04, 32'h4800);
        @(negedge clk); ser_rxd = 1'b0; #1;
        check("R11 echo low", {31'b0, ser_txd}, 32'h0);
        ser_rxd = 1'b1; #1;
        check("R11 echo high", {31'b0, ser_txd}, 32'h1);
        drive_rx(8'h6E, 1'b0, 1'b0, 1'b1);
        bus_read(8'h18, v); check("R11 echo receives", v, 32'h6E);
        bus_write(8'h04, 32'h8800);
        bus_write(8'h1C, 32'h9A);
        count_low(12 * BITC, lows);
        check("R11 local txd idle", lows, 0);
        bus_read(8'h14, v); check("R11 local status", v, 32'h203);
        bus_read(8'h18, v); check("R11 local byte", v, 32'h9A);
        bus_write(8'h04, 32'hC800);
        @(negedge clk); ser_rxd = 1'b0; #1;
        check("R11 remote low", {31'b0, ser_txd}, 32'h0);
        ser_rxd = 1'b1;
        bus_write(8'h1C, 32'h33);
        count_low(12 * BITC, lows);
        check("R11 remote txd follows rxd", lows, 0);
        bus_read(8'h14, v); check("R11 remote no rx", v, 32'h202);
        bus_write(8'h04, 32'h800);
    endtask

    // R12: zero divisor
    task automatic t_zero_div();
        logic [31:0] v; logic [7:0] d; logic p, s; int ll, lows;
        bus_write(8'h20, 32'h0);
        bus_write(8'h1C, 32'h55);
        count_low(200, lows);
        check("R12 line held", lows, 0);
        bus_read(8'h14, v); check("R12 byte held", v, 32'h0);
        bus_write(8'h20, DIVV);
        capture_tx(1'b0, d, p, s, ll);
        check("R12 byte sent later", {24'b0, d}, 32'h55);
        repeat (BITC) @(negedge clk);
    endtask

    // R13: transmitter and receiver resets
    task automatic t_resets();
        logic [31:0] v; int lows;
        bus_write(8'h1C, 32'hF0);
        repeat (3 * BITC) @(negedge clk);
        bus_write(8'h00, 32'h08);
        check("R13 txd high", {31'b0, ser_txd}, 32'h1);
        bus_read(8'h14, v); check("R13 tx status", v, 32'h202);
        count_low(11 * BITC, lows);
        check("R13 frame abandoned", lows, 0);
        drive_rx(8'h42, 1'b0, 1'b0, 1'b1);
        bus_write(8'h00, 32'h04);
        bus_read(8'h14, v); check("R13 rx reset", v, 32'h202);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_enable();
        t_tx_basic();
        t_tx_parity();
        t_rx_basic();
        t_overrun();
        t_framing();
        t_rx_parity();
        t_glitch();
        t_irq();
        t_modes();
        t_zero_div();
        t_resets();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule